// File: doc/BRIEF.md
# Glitch-Tolerant Asynchronous Serial Receiver

This block receives 8-bit asynchronous serial characters (one start bit, eight data bits sent least significant bit first, one stop bit, no parity). It is meant for half-duplex lines where the bus changes direction. While the bus turns around, a short low spike can look like the leading edge of a start bit. The receiver treats a falling edge only as a candidate start. It samples the line again at the middle of the start bit. If the line has gone back high by then, the event is dropped and reported as a rejected glitch. No byte comes out for it.

All timing comes from a strobe `tick_i` that runs at sixteen times the bit rate. The serial input first passes through a two-flop synchronizer. The receiver then samples each data bit at its centre and checks the stop bit at its centre. It returns to hunting for the next start bit at that same point, so a following character may begin before a full stop bit has elapsed. Each received character is presented with a one-cycle strobe. A character whose stop bit reads low is still delivered, with a framing-error flag. After that error, a line that stays low cannot start a new character. The line must go high and then fall again.

Top module: `uart_rx_guard`

## Requirements
- R1: While `rst_ni` is low and after it rises, `valid_o`, `frame_err_o` and `glitch_o` are 0 and `data_o` is 8'h00. The synchronizer resets to the idle (high) level.
- R2: `rxd_i` passes through two flip-flops before any decision uses it. A pin change becomes visible to the receiver two clocks later.
- R3: A start is armed on a tick where the synchronized line is low and the previous tick's sample was high. On the 8th tick after that, a high line cancels the start. A cancelled start raises `glitch_o` for exactly one clock and produces no byte. A low pulse shorter than half a bit therefore yields no byte.
- R4: After a confirmed start, data bits are sampled every 16 ticks and shifted in least significant bit first. The stop bit is sampled 16 ticks after the 8th data bit. On that sample `valid_o` pulses for one clock and `data_o` shows the byte.
- R5: If the stop-bit sample is low, `frame_err_o` pulses together with `valid_o`, and the byte is still presented on `data_o`.
- R6: The hunt for a new start resumes right after the stop-bit centre sample. A falling edge that arrives before the stop bit would have ended is received as a new character.
- R7: After a character with a low stop bit, a line that stays low starts no new character. A new start needs the line to go high and then low again.
- R8: Without `tick_i`, the receiver's state does not advance. A low excursion of the line that begins and ends while no ticks arrive has no effect.
- R9: `data_o` keeps the last received byte until the next `valid_o` pulse.
- R10: `glitch_o` and `valid_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock strobe at 16x the bit rate |
| rxd_i | input | 1 | Asynchronous serial input, idle high |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-cycle strobe: new byte on data_o |
| frame_err_o | output | 1 | One-cycle strobe with valid_o when the stop bit read low |
| glitch_o | output | 1 | One-cycle strobe when a candidate start bit is rejected |

## Verification
A pin change reaches the decision logic two clocks later. The arming tick is the first tick that sees the synchronized low. `glitch_o` appears on the clock after the 8th tick that follows the arming tick. `valid_o`, `frame_err_o` and the new `data_o` appear on the clock after the 152nd tick that follows it. The bench steps a behavioural model at every rising edge, with the same two-clock input delay and the same tick counts. It compares all four outputs against that model at every falling edge, so each result is checked in the exact cycle it is due. Independently of the model, each byte sent is queued and matched against the byte and error flag reported at its strobe. Rejected glitches are counted against the number of short pulses injected.

// File: rtl/uart_rx_guard_pkg.sv
package uart_rx_guard_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/uart_rx_guard_sync.sv
module uart_rx_guard_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '1;
        else         pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '1;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_guard_ctrl.sv
module uart_rx_guard_ctrl
  import uart_rx_guard_pkg::*;
#(
  parameter int unsigned OVS       = 16,
  parameter int unsigned DATA_BITS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  output logic shift_o,
  output logic load_o,
  output logic valid_o,
  output logic frame_err_o,
  output logic glitch_o
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(DATA_BITS - 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BIT_W-1:0] bit_q;
  logic             last_q;
  logic             valid_q, ferr_q, glitch_q;

  wire fall_w    = last_q & ~line_i;
  wire full_w    = (cnt_q == FULL_LAST);
  wire half_w    = (cnt_q == HALF_LAST);

  assign shift_o = tick_i && (state_q == RX_DATA) && full_w;
  assign load_o  = tick_i && (state_q == RX_STOP) && full_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RX_IDLE;
      cnt_q    <= '0;
      bit_q    <= '0;
      last_q   <= 1'b1;
      valid_q  <= 1'b0;
      ferr_q   <= 1'b0;
      glitch_q <= 1'b0;
    end else begin
      valid_q  <= 1'b0;
      ferr_q   <= 1'b0;
      glitch_q <= 1'b0;
      if (tick_i) begin
        last_q <= line_i;
        unique case (state_q)
          RX_IDLE: begin
            // edge-armed: a held-low line never re-arms
            if (fall_w) begin
              state_q <= RX_START;
              cnt_q   <= '0;
            end
          end
          RX_START: begin
            if (half_w) begin
              cnt_q <= '0;
              bit_q <= '0;
              if (line_i) begin
                glitch_q <= 1'b1;
                state_q  <= RX_IDLE;
              end else begin
                state_q  <= RX_DATA;
              end
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          RX_DATA: begin
            if (full_w) begin
              cnt_q <= '0;
              if (bit_q == BIT_LAST) state_q <= RX_STOP;
              else                   bit_q   <= bit_q + BIT_W'(1);
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          RX_STOP: begin
            if (full_w) begin
              // hunt resumes from the stop-bit centre
              cnt_q   <= '0;
              valid_q <= 1'b1;
              ferr_q  <= ~line_i;
              state_q <= RX_IDLE;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign valid_o     = valid_q;
  assign frame_err_o = ferr_q;
  assign glitch_o    = glitch_q;

  // R10
  excl_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(glitch_o && valid_o));
  // R4
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R3
  glitch_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glitch_o |=> !glitch_o);
  // R5
  ferr_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> valid_o);
  // R8
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(state_q) && $stable(cnt_q)));
  // R7
  no_rearm_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_IDLE && tick_i && !last_q) |=> state_q == RX_IDLE);
endmodule

// File: rtl/uart_rx_guard_shreg.sv
module uart_rx_guard_shreg #(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_i,
  input  logic                 load_i,
  input  logic                 line_i,
  output logic [DATA_BITS-1:0] data_o
);
  logic [DATA_BITS-1:0] sh_q, data_q;

  generate
    if (DATA_BITS == 1) begin : g_narrow
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      sh_q <= '0;
        else if (shift_i) sh_q <= line_i;
      end
    end else begin : g_wide
      // LSB arrives first: new bit enters at the top
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      sh_q <= '0;
        else if (shift_i) sh_q <= {line_i, sh_q[DATA_BITS-1:1]};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_q <= '0;
    else if (load_i) data_q <= sh_q;
  end

  assign data_o = data_q;

  // R9
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(data_o));
  // R4
  no_shift_on_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_i && load_i));
endmodule

// File: rtl/uart_rx_guard.sv
module uart_rx_guard #(
  parameter int unsigned OVS         = 16,
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 rxd_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 frame_err_o,
  output logic                 glitch_o
);
  logic line_s, shift_w, load_w;

  uart_rx_guard_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (line_s)
  );

  uart_rx_guard_ctrl #(.OVS(OVS), .DATA_BITS(DATA_BITS)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .line_i     (line_s),
    .shift_o    (shift_w),
    .load_o     (load_w),
    .valid_o    (valid_o),
    .frame_err_o(frame_err_o),
    .glitch_o   (glitch_o)
  );

  uart_rx_guard_shreg #(.DATA_BITS(DATA_BITS)) i_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_w),
    .load_i (load_w),
    .line_i (line_s),
    .data_o (data_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!valid_o && !glitch_o && !frame_err_o));
endmodule

// File: tb/test_uart_rx_guard.sv
module test_uart_rx_guard;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = 16 * TICK_DIV;
  localparam int WD_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic       tick_en = 1'b1;
  logic [7:0] data;
  logic       valid, ferr, glitch;

  int checks = 0, failures = 0, cycles = 0;
  int glitch_seen = 0, glitch_exp = 0;
  int tdiv = 0;
  bit done = 0;
  logic [8:0] exp_q[$];

  // behavioural reference state
  int m_s1, m_s2, m_last, m_st, m_cnt, m_bits;
  logic [7:0] m_sh, m_data;
  bit m_valid, m_fe, m_gl;

  always #5 clk = ~clk;

  uart_rx_guard i_uart_rx_guard (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd),
    .data_o(data), .valid_o(valid), .frame_err_o(ferr), .glitch_o(glitch)
  );

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // tick generator
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TICK_DIV;
    tick <= tick_en && (tdiv == 0);
  end

  // reference model stepped at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_last = 1; m_st = 0; m_cnt = 0; m_bits = 0;
      m_sh = 0; m_data = 0; m_valid = 0; m_fe = 0; m_gl = 0;
    end else begin
      int ln;
      m_valid = 0; m_fe = 0; m_gl = 0;
      if (tick) begin
        ln = m_s2;
        case (m_st)
          0: if (m_last == 1 && ln == 0) begin m_st = 1; m_cnt = 0; end
          1: begin
            m_cnt++;
            if (m_cnt == 8) begin
              if (ln == 1) begin m_gl = 1; m_st = 0; end
              else begin m_st = 2; m_cnt = 0; m_bits = 0; end
            end
          end
          2: begin
            m_cnt++;
            if (m_cnt == 16) begin
              m_sh = {ln[0], m_sh[7:1]};
              m_cnt = 0; m_bits++;
              if (m_bits == 8) m_st = 3;
            end
          end
          default: begin
            m_cnt++;
            if (m_cnt == 16) begin
              m_valid = 1; m_fe = (ln == 0); m_data = m_sh; m_st = 0; m_cnt = 0;
            end
          end
        endcase
        m_last = ln;
      end
      m_s2 = m_s1;
      m_s1 = rxd;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      check("R2 R4 valid", valid, m_valid);
      check("R5 frame_err", ferr, m_fe);
      check("R3 glitch", glitch, m_gl);
      check("R9 data", data, m_data);
      if (glitch) glitch_seen++;
      if (valid) begin
        if (exp_q.size() == 0) check("R4 unexpected byte", 1, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check("R4 byte", data, e[7:0]);
          check("R5 flag", ferr, e[8]);
        end
      end
      if (cycles > WD_LIMIT) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WD_LIMIT);
        report();
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit stop_low, input int stop_clk);
    exp_q.push_back({stop_low, b});
    rxd <= 1'b0; wait_clk(BIT_CLK);
    for (int i = 0; i < 8; i++) begin
      rxd <= b[i]; wait_clk(BIT_CLK);
    end
    rxd <= ~stop_low; wait_clk(stop_clk);
  endtask

  task automatic pulse_low(input int n);
    rxd <= 1'b0; wait_clk(n);
    rxd <= 1'b1;
  endtask

  initial begin
    wait_clk(3);
    // R1 reset state
    check("R1 valid", valid, 0);
    check("R1 glitch", glitch, 0);
    check("R1 frame_err", ferr, 0);
    check("R1 data", data, 0);
    rst_n <= 1'b1;
    wait_clk(20);

    // R4 several data patterns
    send_byte(8'hA5, 0, BIT_CLK); wait_clk(100);
    send_byte(8'h00, 0, BIT_CLK); wait_clk(100);
    send_byte(8'hFF, 0, BIT_CLK); wait_clk(100);
    send_byte(8'h3C, 0, BIT_CLK); wait_clk(200);

    // R3 short pulses are rejected
    pulse_low(20); glitch_exp++; wait_clk(200);
    pulse_low(10); glitch_exp++; wait_clk(200);
    // R3 pulse longer than half a bit is a real start: reads as 0xFF
    exp_q.push_back({1'b0, 8'hFF});
    pulse_low(40); wait_clk(700);

    // R6 next start arrives before the stop bit would end
    send_byte(8'h5A, 0, 48);
    send_byte(8'hC3, 0, BIT_CLK); wait_clk(100);

    // R5 and R7: low stop bit, line then held low
    send_byte(8'h81, 1, BIT_CLK);
    wait_clk(400);
    rxd <= 1'b1; wait_clk(200);
    send_byte(8'h6E, 0, BIT_CLK); wait_clk(200);

    // R8 no ticks while line dips
    tick_en <= 1'b0; wait_clk(10);
    pulse_low(100); wait_clk(20);
    tick_en <= 1'b1; wait_clk(300);
    send_byte(8'h17, 0, BIT_CLK); wait_clk(200);

    check("R3 glitch count", glitch_seen, glitch_exp);
    check("R4 pending bytes", exp_q.size(), 0);
    done = 1;
    report();
  end
endmodule